// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves one byte at a time over two wires. One wire carries data in either direction, and the other wire is a shift clock that the block always drives. Only one direction is active during a transfer. A byte write starts a transmit. A receive strobe starts a reception. In both directions eight bits move with the least significant bit first, and a sticky done flag closes the transfer.

The shift rate comes from one of three sources. The first is the system clock through a fixed divider, which has a fast family (divide by 2 or 4) and a compatibility family (divide by 3 or 6). The second is an overflow strobe from an external timer, divided by 2 or 4. The third is an overflow strobe from an external baud generator, divided by 1 or 2. The rate-high control picks the smaller divider. It also moves transmitted data half a shift period ahead of its sampling edge. The timer and the baud generator are outside this block and arrive only as single-cycle strobes. The rate controls must stay constant while a transfer runs.

Top module: `sync_shift_port`

## Requirements
- R1: After reset the shift clock is high, the data-line enable is low and the done flag is low.
- R2: A byte write (tx_wr) accepted while idle with done low drives data_en high for the whole transfer. It puts the byte on data_out one bit per shift period, bit 0 first. Each bit is valid just before the rising edge of its shift clock period.
- R3: A receive strobe (rx_go) accepted while idle with done low keeps data_en low. It samples data_in at each of the eight rising shift clock edges. After done, the first sample is in rx_byte bit 0 and the last is in bit 7.
- R4: With src_brg=0, src_tmr=0 and fast_mode=1, the shift clock period is 4 system cycles (2 low, 2 high) when rate_hi=0, and 2 cycles (1 low, 1 high) when rate_hi=1.
- R5: With src_brg=0, src_tmr=0 and fast_mode=0, the period is 6 cycles (3 low, 3 high) when rate_hi=0, and 3 cycles (1 low, 2 high) when rate_hi=1.
- R6: With src_brg=0 and src_tmr=1, the period is 4 tmr_ovf strobes when rate_hi=0 and 2 strobes when rate_hi=1. fast_mode has no effect.
- R7: With src_brg=1, the period is 2 brg_ovf strobes when rate_hi=0 and 1 strobe when rate_hi=1. Both src_tmr and fast_mode are ignored.
- R8: With rate_hi=0, data_out keeps its bit across the rising shift clock edge and changes only where the clock falls. With rate_hi=1, data_out moves to the next bit at the rising edge that samples the current bit.
- R9: done rises at the clock edge that ends the eighth shift period. For the system-clock source this is 8 times the period in cycles after the edge that accepted the start. done then holds until done_clr is applied while idle; a clear in the same cycle as the set loses to the set.
- R10: While done is high, tx_wr and rx_go are ignored. The shift clock stays high and data_en stays low.
- R11: During a transfer, tx_wr and rx_go are ignored. The byte in flight and the direction do not change.
- R12: Whenever no transfer runs, the shift clock is high and data_en is low. tx_wr takes priority over rx_go when both arrive together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fast_mode | input | 1 | 1 selects the divide-by-2/4 family, 0 the divide-by-3/6 family |
| src_brg | input | 1 | 1 selects the baud-generator strobe as the rate source |
| src_tmr | input | 1 | 1 selects the timer strobe when src_brg is 0 |
| rate_hi | input | 1 | Selects the smaller divider and the early data phase |
| tmr_ovf | input | 1 | Timer overflow strobe, one cycle wide |
| brg_ovf | input | 1 | Baud-generator overflow strobe, one cycle wide |
| tx_wr | input | 1 | Starts a transmit of tx_byte |
| tx_byte | input | 8 | Byte to transmit |
| rx_go | input | 1 | Starts a reception |
| done_clr | input | 1 | Clears the done flag |
| done | output | 1 | Transfer finished, sticky |
| rx_byte | output | 8 | Received byte, valid while done follows a reception |
| data_in | input | 1 | Data line input |
| data_out | output | 1 | Data line output value |
| data_en | output | 1 | Data line output enable |
| sclk | output | 1 | Shift clock, idles high |

## Verification
A start strobe is taken at edge E0, and sclk goes low in the cycle right after it. With the system-clock source, done must read high exactly 8 times the period in cycles after E0. The bench counts rising edges from E0 and compares that count with the expected value. Each transmitted bit is taken from the data_out sample just before the sclk rise. The phase is checked on the sample just after it. Each interval between rises is compared with the period times the strobe spacing. Ignore and clear checks are read one to four cycles after their strobe, once the registered state has settled.

// File: rtl/ssp_pkg.sv
// Shared types for the synchronous shift port.
// Assumes: a shift period never exceeds the range of per_t.
package ssp_pkg;
    localparam int unsigned PER_W = 3;
    typedef logic [PER_W-1:0] per_t;

    typedef enum logic [1:0] {
        UNIT_SYS = 2'd0,
        UNIT_TMR = 2'd1,
        UNIT_BRG = 2'd2
    } unit_src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_RX   = 2'd2
    } port_st_e;
endpackage

// File: rtl/ssp_rate_sel.sv
// Rate source selection: picks the unit strobe that advances the shift
// phase, how many units make one shift period, and how many of them
// the clock spends low (the floor of half the period).
// Assumes: tmr_ovf and brg_ovf are single-cycle strobes.
module ssp_rate_sel
    import ssp_pkg::*;
(
    input  logic fast_mode,
    input  logic src_brg,
    input  logic src_tmr,
    input  logic rate_hi,
    input  logic tmr_ovf,
    input  logic brg_ovf,
    output logic unit_stb,
    output per_t per_len,
    output per_t low_len
);
    unit_src_e src;

    // Source priority: baud generator first, then timer, then system clock.
    always_comb begin
        if (src_brg)      src = UNIT_BRG;
        else if (src_tmr) src = UNIT_TMR;
        else              src = UNIT_SYS;
    end

    // Unit strobe and period length for the selected source.
    always_comb begin
        unit_stb = 1'b1;
        per_len  = per_t'(4);
        case (src)
            UNIT_SYS: begin
                unit_stb = 1'b1;
                if (fast_mode) per_len = rate_hi ? per_t'(2) : per_t'(4);
                else           per_len = rate_hi ? per_t'(3) : per_t'(6);
            end
            UNIT_TMR: begin
                unit_stb = tmr_ovf;
                per_len  = rate_hi ? per_t'(2) : per_t'(4);
            end
            UNIT_BRG: begin
                unit_stb = brg_ovf;
                per_len  = rate_hi ? per_t'(1) : per_t'(2);
            end
            default: begin
                unit_stb = 1'b1;
                per_len  = per_t'(4);
            end
        endcase
    end

    assign low_len = per_len >> 1;
endmodule

// File: rtl/ssp_phase_ctr.sv
// Shift period sequencer: counts unit strobes inside a period and
// flags the mid point (clock rises) and the end (clock falls).
// With a one-unit period the low phase is the single cycle after the
// period starts, and a strobe in that cycle is not counted.
// Assumes: strobes in one-unit mode are at least two cycles apart.
module ssp_phase_ctr
    import ssp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic start,
    input  logic unit_stb,
    input  per_t per_len,
    input  per_t low_len,
    output logic mid_evt,
    output logic end_evt,
    output logic clk_low
);
    per_t ucnt;
    logic fresh;
    logic unity;
    logic count_ok;

    assign unity    = (low_len == '0);
    assign count_ok = run && unit_stb && !(unity && fresh);
    assign mid_evt  = run && (unity ? fresh : (unit_stb && ucnt == low_len - per_t'(1)));
    assign end_evt  = count_ok && (ucnt == per_len - per_t'(1));
    assign clk_low  = run && (unity ? fresh : (ucnt < low_len));

    // Unit counter and period-start marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ucnt  <= '0;
            fresh <= 1'b0;
        end else if (start || end_evt) begin
            ucnt  <= '0;
            fresh <= 1'b1;
        end else begin
            if (count_ok) ucnt <= ucnt + per_t'(1);
            fresh <= 1'b0;
        end
    end
endmodule

// File: rtl/ssp_shifter.sv
// Transfer control and shift register: accepts a start, shifts out
// bit 0 first on transmit or gathers bits from the top on receive,
// counts periods and raises the sticky done flag.
// Assumes: mid_evt and end_evt come from ssp_phase_ctr and are low while idle.
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              rx_go,
    input  logic              done_clr,
    input  logic              data_in,
    input  logic              rate_hi,
    input  logic              mid_evt,
    input  logic              end_evt,
    output logic              start,
    output logic              run,
    output logic              tx_active,
    output logic              done,
    output logic              data_out,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    typedef logic [BIT_W-1:0] bidx_t;
    localparam bidx_t LAST = bidx_t'(DATA_W - 1);

    port_st_e          st;
    logic [DATA_W-1:0] sreg;
    bidx_t             bidx;
    logic              go_tx;
    logic              go_rx;
    logic              tx_shift;
    logic              last_end;

    assign go_tx     = (st == ST_IDLE) && !done && tx_wr;
    assign go_rx     = (st == ST_IDLE) && !done && !tx_wr && rx_go;
    assign start     = go_tx || go_rx;
    assign run       = (st != ST_IDLE);
    assign tx_active = (st == ST_TX);
    assign tx_shift  = rate_hi ? mid_evt : end_evt;
    assign last_end  = end_evt && (bidx == LAST);
    assign data_out  = sreg[0];
    assign rx_byte   = sreg;

    // Transfer state: idle until accepted, back to idle after the last period.
    always_ff @(posedge clk) begin
        if (!rst_n)        st <= ST_IDLE;
        else if (go_tx)    st <= ST_TX;
        else if (go_rx)    st <= ST_RX;
        else if (last_end) st <= ST_IDLE;
    end

    // Period index within the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)       bidx <= '0;
        else if (start)   bidx <= '0;
        else if (end_evt) bidx <= bidx + bidx_t'(1);
    end

    // Shift register: load on transmit, shift right, fill from the top on receive.
    always_ff @(posedge clk) begin
        if (!rst_n)                         sreg <= '0;
        else if (go_tx)                     sreg <= tx_byte;
        else if (st == ST_TX && tx_shift)   sreg <= sreg >> 1;
        else if (st == ST_RX && mid_evt)    sreg <= {data_in, sreg[DATA_W-1:1]};
    end

    // Sticky done flag; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)        done <= 1'b0;
        else if (last_end) done <= 1'b1;
        else if (done_clr) done <= 1'b0;
    end
endmodule

// File: rtl/sync_shift_port.sv
// Top of the two-wire half-duplex shift port: rate selection, period
// sequencing and the shifter, with the shift clock idling high.
// Assumes: rate controls are stable from start to done.
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_mode,
    input  logic              src_brg,
    input  logic              src_tmr,
    input  logic              rate_hi,
    input  logic              tmr_ovf,
    input  logic              brg_ovf,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              rx_go,
    input  logic              done_clr,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    input  logic              data_in,
    output logic              data_out,
    output logic              data_en,
    output logic              sclk
);
    logic unit_stb;
    per_t per_len;
    per_t low_len;
    logic mid_evt;
    logic end_evt;
    logic clk_low;
    logic start;
    logic run;
    logic tx_active;

    ssp_rate_sel u_rate (
        .fast_mode (fast_mode),
        .src_brg   (src_brg),
        .src_tmr   (src_tmr),
        .rate_hi   (rate_hi),
        .tmr_ovf   (tmr_ovf),
        .brg_ovf   (brg_ovf),
        .unit_stb  (unit_stb),
        .per_len   (per_len),
        .low_len   (low_len)
    );

    ssp_phase_ctr u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .start    (start),
        .unit_stb (unit_stb),
        .per_len  (per_len),
        .low_len  (low_len),
        .mid_evt  (mid_evt),
        .end_evt  (end_evt),
        .clk_low  (clk_low)
    );

    ssp_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_wr     (tx_wr),
        .tx_byte   (tx_byte),
        .rx_go     (rx_go),
        .done_clr  (done_clr),
        .data_in   (data_in),
        .rate_hi   (rate_hi),
        .mid_evt   (mid_evt),
        .end_evt   (end_evt),
        .start     (start),
        .run       (run),
        .tx_active (tx_active),
        .done      (done),
        .data_out  (data_out),
        .rx_byte   (rx_byte)
    );

    assign sclk    = !clk_low;
    assign data_en = tx_active;
endmodule

// File: rtl/ssp_checker.sv
// Property checker for sync_shift_port, attached with bind.
// Assumes: busy is the top's internal transfer-running signal.
module ssp_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_wr,
    input logic rx_go,
    input logic done_clr,
    input logic done,
    input logic sclk,
    input logic data_en,
    input logic busy,
    input logic fast_mode,
    input logic src_brg,
    input logic src_tmr,
    input logic rate_hi
);
    logic sys_src;
    assign sys_src = !src_brg && !src_tmr;

    assert_idle_lines_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk && !data_en));

    assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done);

    assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !busy) |=> !done);

    assert_done_ends_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy));

    assert_blocked_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && tx_wr) |=> (sclk && !data_en));

    assert_blocked_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_go) |=> (sclk && !data_en));

    assert_fast_hi_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sys_src && fast_mode && rate_hi && !sclk) |=> sclk);

    assert_fast_lo_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sys_src && fast_mode && !rate_hi && $fell(sclk)) |=> !sclk);

    assert_compat_hi_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sys_src && !fast_mode && rate_hi && !sclk) |=> sclk);

    assert_compat_lo_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sys_src && !fast_mode && !rate_hi && $fell(sclk)) |=> (!sclk ##1 !sclk));
endmodule

bind sync_shift_port ssp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_wr     (tx_wr),
    .rx_go     (rx_go),
    .done_clr  (done_clr),
    .done      (done),
    .sclk      (sclk),
    .data_en   (data_en),
    .busy      (run),
    .fast_mode (fast_mode),
    .src_brg   (src_brg),
    .src_tmr   (src_tmr),
    .rate_hi   (rate_hi)
);

// File: tb/sim_sync_shift_port.sv
module sim_sync_shift_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast_mode = 1'b1, src_brg = 1'b0, src_tmr = 1'b0, rate_hi = 1'b0;
    logic       tmr_ovf = 1'b0, brg_ovf = 1'b0;
    logic       tx_wr = 1'b0, rx_go = 1'b0, done_clr = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       data_in = 1'b0;
    logic       done, data_out, data_en, sclk;
    logic [7:0] rx_byte;

    int n_chk = 0;
    int n_fail = 0;
    int tmr_m = 3;
    int brg_m = 3;
    bit finished = 1'b0;

    sync_shift_port u0 (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .src_brg(src_brg),
        .src_tmr(src_tmr), .rate_hi(rate_hi), .tmr_ovf(tmr_ovf), .brg_ovf(brg_ovf),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .rx_go(rx_go), .done_clr(done_clr),
        .done(done), .rx_byte(rx_byte), .data_in(data_in), .data_out(data_out),
        .data_en(data_en), .sclk(sclk)
    );

    always #5 clk = ~clk;

    // Periodic overflow strobes, driven away from the active edge.
    initial begin
        int tc = 0;
        int bc = 0;
        forever begin
            @(negedge clk);
            tc = tc + 1;
            bc = bc + 1;
            tmr_ovf = (tc >= tmr_m);
            if (tc >= tmr_m) tc = 0;
            brg_ovf = (bc >= brg_m);
            if (bc >= brg_m) bc = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_units(input bit fm, input bit sb, input bit st, input bit hi);
        if (sb)      return hi ? 1 : 2;
        else if (st) return hi ? 2 : 4;
        else if (fm) return hi ? 2 : 4;
        else         return hi ? 3 : 6;
    endfunction

    function automatic string rate_req(input bit sb, input bit st, input bit fm);
        if (sb)      return "R7";
        else if (st) return "R6";
        else if (fm) return "R4";
        else         return "R5";
    endfunction

    // One transfer with full waveform observation.
    task automatic run_xfer(input bit is_tx, input logic [7:0] val, input bit fm,
                            input bit sb, input bit st, input bit hi, input bit poke);
        int   n_u;
        int   exp_per;
        int   cyc;
        int   idx;
        int   last_rise;
        bit   prev_sclk;
        bit   prev_sd;
        bit   per_bad;
        bit   ph_bad;
        bit   oe_bad;
        logic [7:0] got;
        n_u = exp_units(fm, sb, st, hi);
        exp_per = n_u * (sb ? brg_m : (st ? tmr_m : 1));
        @(negedge clk);
        fast_mode = fm; src_brg = sb; src_tmr = st; rate_hi = hi;
        repeat (2) @(negedge clk);
        if (is_tx) begin tx_wr = 1'b1; tx_byte = val; end
        else       rx_go = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_wr = 1'b0; rx_go = 1'b0;
        cyc = 0; idx = 0; last_rise = 0;
        per_bad = 0; ph_bad = 0; oe_bad = 0; got = 8'h00;
        prev_sclk = sclk; prev_sd = data_out;
        if (data_en != is_tx) oe_bad = 1;
        data_in = val[0];
        while (!done && cyc < 600) begin
            @(posedge clk);
            cyc = cyc + 1;
            @(negedge clk);
            if (poke && cyc == 3) begin
                tx_wr = 1'b1; tx_byte = ~val; rx_go = 1'b1;
            end else begin
                tx_wr = 1'b0; rx_go = 1'b0;
            end
            if (!done && data_en != is_tx) oe_bad = 1;
            if (!prev_sclk && sclk && idx < 8) begin
                got[idx] = prev_sd;
                if (is_tx) begin
                    if (hi) begin
                        if (idx < 7 && data_out != val[idx+1]) ph_bad = 1;
                    end else if (data_out != prev_sd) ph_bad = 1;
                end
                if (idx > 0 && !(n_u == 1 && idx == 1) && (cyc - last_rise) != exp_per)
                    per_bad = 1;
                last_rise = cyc;
                idx = idx + 1;
            end
            prev_sclk = sclk;
            prev_sd = data_out;
            data_in = (idx < 8) ? val[idx] : 1'b0;
        end
        tx_wr = 1'b0; rx_go = 1'b0;
        check(done == 1'b1, "R9 done after eighth period", done, 1);
        check(idx == 8, "R2/R3 eight rising edges", idx, 8);
        if (!sb && !st) check(cyc == 8 * n_u, "R9 done latency", cyc, 8 * n_u);
        check(!per_bad, rate_req(sb, st, fm), per_bad, 0);
        if (is_tx) begin
            check(got == val, poke ? "R2 tx bits (R11 poke)" : "R2 tx bits", got, val);
            check(!ph_bad, "R8 data phase", ph_bad, 0);
            check(!oe_bad, "R2 data_en during tx", oe_bad, 0);
        end else begin
            check(rx_byte == val, poke ? "R3 rx byte (R11 poke)" : "R3 rx byte", rx_byte, val);
            check(!oe_bad, "R3 data_en low during rx", oe_bad, 0);
        end
        if (poke) check(!oe_bad, "R11 direction kept", oe_bad, 0);
        repeat (3) @(negedge clk);
        check(done == 1'b1, "R9 done holds", done, 1);
        // R10: starts ignored while done is set.
        if (is_tx) rx_go = 1'b1; else tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0; rx_go = 1'b0;
        repeat (3) @(negedge clk);
        check(sclk && !data_en && done, "R10 start blocked", {sclk, data_en, done}, 3'b101);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        check(done == 1'b0, "R9 done cleared", done, 0);
        check(sclk && !data_en, "R12 idle lines", {sclk, data_en}, 2'b10);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(sclk == 1'b1, "R1 sclk high in reset", sclk, 1);
        check(data_en == 1'b0, "R1 data_en low in reset", data_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && sclk == 1'b1 && data_en == 1'b0, "R1 state after reset",
              {done, sclk, data_en}, 3'b010);
        // Directed corners: every divider setting, both directions.
        run_xfer(1, 8'hA5, 1, 0, 0, 0, 0);
        run_xfer(1, 8'h3C, 1, 0, 0, 1, 0);
        run_xfer(1, 8'h81, 0, 0, 0, 0, 0);
        run_xfer(0, 8'h6E, 0, 0, 0, 1, 0);
        tmr_m = 3;
        run_xfer(1, 8'hF0, 1, 0, 1, 0, 0);
        run_xfer(0, 8'h0F, 0, 0, 1, 1, 0);
        brg_m = 4; tmr_m = 2;
        run_xfer(1, 8'h5A, 1, 1, 1, 0, 0);
        run_xfer(1, 8'hC3, 0, 1, 1, 1, 0);
        run_xfer(0, 8'h96, 1, 1, 0, 1, 1);
        run_xfer(1, 8'h01, 1, 0, 0, 0, 1);
        // R12: simultaneous starts, transmit wins.
        @(negedge clk);
        fast_mode = 1; src_brg = 0; src_tmr = 0; rate_hi = 1;
        tx_wr = 1'b1; rx_go = 1'b1; tx_byte = 8'hFF;
        @(negedge clk);
        tx_wr = 1'b0; rx_go = 1'b0;
        check(data_en == 1'b1, "R12 tx priority", data_en, 1);
        while (!done) @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        // Constrained random transfers.
        for (int i = 0; i < 40; i++) begin
            tmr_m = 2 + int'($urandom % 4);
            brg_m = 2 + int'($urandom % 4);
            run_xfer(bit'($urandom % 2), 8'($urandom), bit'($urandom % 2),
                     bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2),
                     bit'($urandom % 4 == 0));
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule